// File: doc/BRIEF.md
# Quadrature Mixer With One-Period Sliding Averager

This block pulls the fundamental of a sampled grid voltage out of a noisy, harmonic-rich waveform. Every accepted ADC sample is multiplied by a cosine reference and, separately, by a sine reference. Both references are read from a quarter-wave sine table addressed by a phase accumulator. The accumulator advances by a frequency tuning word once per sample, so the references run at the measured grid frequency.

Each product stream feeds its own ring buffer and running sum over the last N samples. N is the number of samples in one grid period. On every sample the sum adds the newest product and drops the product that leaves the window. The block reports twice the sum divided by N for each channel. This is a single-bin DFT. With a window of exactly one period, harmonics and the double-frequency mixing term cancel. The cosine and sine averages then give the in-phase and quadrature amplitudes of the fundamental, scaled by the reference amplitude. A later stage can take the arctangent of these to get the phase angle. That stage is not part of this block.

Top module: `quad_mix_avg`

## Requirements
- R1: After reset, `avg_vld` is 0, `cos_avg` and `sin_avg` are 0, and the phase accumulator is 0.
- R2: Let k = phase[31:22]. The sine reference is round(32767·sin(2π(k+0.5)/1024)). The cosine reference uses the same formula at (k+256) mod 1024. The references are taken from the phase value held when the sample is accepted. After each accepted sample the phase then advances by `phase_inc`, modulo 2^32.
- R3: Each sample (16-bit two's complement) is multiplied by the cosine reference and by the sine reference. The products are full-width signed values and feed separate channels.
- R4: Each channel keeps S_n = S_(n−1) + D_n − D_(n−N). Products older than the start of the current window count as zero.
- R5: Each output equals 2·S_n/N, truncated toward zero. It is refreshed on every accepted sample: a strobe seen at rising edge E updates the outputs at edge E+1. Without a strobe the outputs hold.
- R6: `avg_vld` stays 0 until N samples have entered the window since reset or since the last change of N. It then rises and stays 1 while N is unchanged.
- R7: When `win_len` differs from the window length in use, the window restarts on the next edge. The sums are cleared, both outputs go to 0 and `avg_vld` goes to 0.
- R8: A `win_len` below 2 or above NMAX (64) admits no sample into the window. The outputs stay 0 and `avg_vld` stays 0.
- R9: With one period of whole-cycle sampling, a third-harmonic input gives averages near zero (|avg| < 2^20). A fundamental of amplitude A gives `cos_avg` within 1% of A·32767 when its phase is near zero.
- R10: The running sums are wide enough (product width plus log2 NMAX) that they never leave ±NMAX·2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp | input | 16 | Signed grid-voltage sample |
| phase_inc | input | 32 | Phase step per sample (tuning word) |
| win_len | input | 7 | Window length N in samples |
| avg_vld | output | 1 | Window full, averages meaningful |
| cos_avg | output | 33 | Signed in-phase average 2·S/N |
| sin_avg | output | 33 | Signed quadrature average 2·S/N |

## Verification
A phase-shifted fundamental sampled 16 times per period shows that the cosine channel settles to the amplitude times the reference scale once the window fills. A third harmonic over a 64-sample period shows that whole-period averaging rejects it rather than passing it as leakage. Pseudo-random samples, including the most negative code, are run with an irregular tuning word at the shortest and longest legal windows. These separate correct oldest-product removal and pointer wrap from off-by-one window errors. Changing the window length mid-run and moving to lengths of 1 and 65 tell a proper restart apart from stale sums that survive.

// File: rtl/qm_pkg.sv
package qm_pkg;

    typedef enum int {
        CH_COS = 0,
        CH_SIN = 1
    } chan_e;

    function automatic logic win_ok(input int n, input int nmax);
        return (n >= 2) && (n <= nmax);
    endfunction

endpackage

// File: rtl/qm_sincos.sv
module qm_sincos #(
    parameter int PHASE_W = 32,
    parameter int LUT_AW  = 8,
    parameter int REF_W   = 16
) (
    input  logic [PHASE_W-1:0]      phase,
    output logic signed [REF_W-1:0] cos_ref,
    output logic signed [REF_W-1:0] sin_ref
);
    localparam int LUT_SIZE = 1 << LUT_AW;
    localparam int FULL_AW  = LUT_AW + 2;
    localparam int AMP      = (1 << (REF_W - 1)) - 1;

    logic signed [REF_W-1:0] rom [LUT_SIZE];

    // quarter-wave table, sampled at half-step offsets so folding is exact
    for (genvar i = 0; i < LUT_SIZE; i++) begin : g_rom
        localparam real ANG = 2.0 * 3.14159265358979323846 * (real'(i) + 0.5) / real'(4 * LUT_SIZE);
        localparam int  VAL = int'(real'(AMP) * $sin(ANG));
        assign rom[i] = REF_W'(VAL);
    end

    logic [FULL_AW-1:0]      k_d [2];
    logic [LUT_AW-1:0]       j_d [2];
    logic signed [REF_W-1:0] m_d [2];
    logic signed [REF_W-1:0] r_d [2];

    always_comb begin
        k_d[0] = phase[PHASE_W-1 -: FULL_AW] + FULL_AW'(LUT_SIZE); // cosine: quarter turn ahead
        k_d[1] = phase[PHASE_W-1 -: FULL_AW];
        for (int c = 0; c < 2; c++) begin
            j_d[c] = k_d[c][FULL_AW-2] ? ~k_d[c][LUT_AW-1:0] : k_d[c][LUT_AW-1:0];
            m_d[c] = rom[j_d[c]];
            r_d[c] = k_d[c][FULL_AW-1] ? -m_d[c] : m_d[c];
        end
    end

    assign cos_ref = r_d[0];
    assign sin_ref = r_d[1];

    // R2: the two references stay on the unit circle within rounding
    logic signed [2*REF_W+1:0] mag2;
    always_comb begin
        mag2 = (2*REF_W+2)'(cos_ref) * (2*REF_W+2)'(cos_ref)
             + (2*REF_W+2)'(sin_ref) * (2*REF_W+2)'(sin_ref);
        a_r2_unit_circle: assert (mag2 >= (2*REF_W+2)'((AMP-1)*(AMP-1)) &&
                                  mag2 <= (2*REF_W+2)'((AMP+1)*(AMP+1)))
            else $error("R2 reference pair off the unit circle");
    end

endmodule

// File: rtl/qm_mixer.sv
module qm_mixer #(
    parameter int SAMPLE_W = 16,
    parameter int REF_W    = 16,
    parameter int PHASE_W  = 32,
    localparam int PROD_W  = SAMPLE_W + REF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic [PHASE_W-1:0]         phase_inc,
    input  logic signed [REF_W-1:0]    cos_ref,
    input  logic signed [REF_W-1:0]    sin_ref,
    output logic [PHASE_W-1:0]         phase,
    output logic                       prod_vld,
    output logic signed [PROD_W-1:0]   prod_cos,
    output logic signed [PROD_W-1:0]   prod_sin
);
    typedef struct packed {
        logic [PHASE_W-1:0]       phase;
        logic                     vld;
        logic signed [PROD_W-1:0] pc;
        logic signed [PROD_W-1:0] ps;
    } mix_t;

    mix_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (smp_vld) begin
            st_d.vld   = 1'b1;
            st_d.pc    = PROD_W'(smp) * PROD_W'(cos_ref);
            st_d.ps    = PROD_W'(smp) * PROD_W'(sin_ref);
            st_d.phase = st_q.phase + phase_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign prod_vld = st_q.vld;
    assign prod_cos = st_q.pc;
    assign prod_sin = st_q.ps;

    // R3: a product appears exactly one edge after each strobe
    a_r3_prod_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> prod_vld)
        else $error("R3 product missing after strobe");

endmodule

// File: rtl/qm_ring.sv
module qm_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // read returns the entry about to be overwritten (oldest in window)
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/qm_window.sv
module qm_window #(
    parameter int PROD_W = 32,
    parameter int NMAX   = 64,
    localparam int NW    = $clog2(NMAX + 1),
    localparam int AW    = $clog2(NMAX),
    localparam int ACC_W = PROD_W + AW,
    localparam int OUT_W = PROD_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NW-1:0]            win_len,
    input  logic                     prod_vld,
    input  logic signed [PROD_W-1:0] prod_cos,
    input  logic signed [PROD_W-1:0] prod_sin,
    output logic                     avg_vld,
    output logic signed [OUT_W-1:0]  avg_cos,
    output logic signed [OUT_W-1:0]  avg_sin
);
    import qm_pkg::*;

    localparam longint SUM_LIM = longint'(NMAX) * (longint'(1) << (PROD_W - 2));

    typedef struct packed {
        logic [NW-1:0]                n;
        logic [AW-1:0]                ptr;
        logic [NW-1:0]                fill;
        logic [1:0][ACC_W-1:0]        sum;
        logic [1:0][OUT_W-1:0]        avg;
        logic                         vld;
    } win_t;

    win_t st_d, st_q;

    logic signed [PROD_W-1:0] prod_a [2];
    logic [PROD_W-1:0]        rd_a   [2];
    logic                     we_d;

    assign prod_a[CH_COS] = prod_cos;
    assign prod_a[CH_SIN] = prod_sin;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        qm_ring #(.W(PROD_W), .DEPTH(NMAX)) u_ring (
            .clk   (clk),
            .we    (we_d),
            .addr  (st_q.ptr),
            .wdata (prod_a[c]),
            .rdata (rd_a[c])
        );
    end

    function automatic logic signed [OUT_W-1:0] scale2(input logic signed [ACC_W-1:0] s,
                                                       input logic [NW-1:0] n);
        logic signed [ACC_W+1:0] num;
        logic signed [ACC_W+1:0] den;
        logic signed [ACC_W+1:0] quo;
        num = {s[ACC_W-1], s, 1'b0};
        den = {{(ACC_W + 2 - NW){1'b0}}, n};
        quo = num / den;
        return quo[OUT_W-1:0];
    endfunction

    logic                    restart;
    logic                    full;
    logic signed [ACC_W-1:0] old_v [2];
    logic signed [ACC_W-1:0] new_s [2];

    always_comb begin
        st_d    = st_q;
        restart = (win_len != st_q.n);
        full    = (st_q.fill == st_q.n);
        we_d    = 1'b0;
        for (int c = 0; c < 2; c++) begin
            old_v[c] = full ? ACC_W'($signed(rd_a[c])) : '0;
            new_s[c] = $signed(st_q.sum[c]) + ACC_W'(prod_a[c]) - old_v[c];
        end
        if (restart) begin
            st_d     = '0;
            st_d.n   = win_len;
        end else if (prod_vld && win_ok(int'(st_q.n), NMAX)) begin
            we_d = 1'b1;
            for (int c = 0; c < 2; c++) begin
                st_d.sum[c] = new_s[c];
                st_d.avg[c] = scale2(new_s[c], st_q.n);
            end
            st_d.ptr = (NW'(st_q.ptr) == st_q.n - NW'(1)) ? '0 : st_q.ptr + AW'(1);
            if (!full) begin
                st_d.fill = st_q.fill + NW'(1);
                st_d.vld  = (st_q.fill + NW'(1) == st_q.n);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avg_vld = st_q.vld;
    assign avg_cos = $signed(st_q.avg[CH_COS]);
    assign avg_sin = $signed(st_q.avg[CH_SIN]);

    // R7: a new window length clears outputs and validity on the next edge
    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (win_len != st_q.n) |=> (!avg_vld && avg_cos == '0 && avg_sin == '0))
        else $error("R7 restart left stale state");

    // R8: an out-of-range length never yields a valid average
    a_r8_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !win_ok(int'(win_len), NMAX) |=> !avg_vld)
        else $error("R8 valid with illegal length");

    // R6: validity is sticky while the length is unchanged
    a_r6_vld_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_vld && win_len == st_q.n) |=> avg_vld)
        else $error("R6 valid dropped");

    // R5: with no product the averages hold
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!prod_vld && win_len == st_q.n) |=> ($stable(avg_cos) && $stable(avg_sin)))
        else $error("R5 average moved without a sample");

    // R10: running sums stay inside the worst-case window bound
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'($signed(st_q.sum[0])) <= SUM_LIM && longint'($signed(st_q.sum[0])) >= -SUM_LIM &&
         longint'($signed(st_q.sum[1])) <= SUM_LIM && longint'($signed(st_q.sum[1])) >= -SUM_LIM))
        else $error("R10 running sum out of range");

endmodule

// File: rtl/quad_mix_avg.sv
module quad_mix_avg #(
    parameter int SAMPLE_W = 16,
    parameter int REF_W    = 16,
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 8,
    parameter int NMAX     = 64,
    localparam int NW      = $clog2(NMAX + 1),
    localparam int PROD_W  = SAMPLE_W + REF_W,
    localparam int OUT_W   = PROD_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp,
    input  logic [PHASE_W-1:0]         phase_inc,
    input  logic [NW-1:0]              win_len,
    output logic                       avg_vld,
    output logic signed [OUT_W-1:0]    cos_avg,
    output logic signed [OUT_W-1:0]    sin_avg
);
    logic [PHASE_W-1:0]       phase;
    logic signed [REF_W-1:0]  cos_ref;
    logic signed [REF_W-1:0]  sin_ref;
    logic                     prod_vld;
    logic signed [PROD_W-1:0] prod_cos;
    logic signed [PROD_W-1:0] prod_sin;

    qm_sincos #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .REF_W(REF_W)) u_sincos (
        .phase   (phase),
        .cos_ref (cos_ref),
        .sin_ref (sin_ref)
    );

    qm_mixer #(.SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .PHASE_W(PHASE_W)) u_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp       (smp),
        .phase_inc (phase_inc),
        .cos_ref   (cos_ref),
        .sin_ref   (sin_ref),
        .phase     (phase),
        .prod_vld  (prod_vld),
        .prod_cos  (prod_cos),
        .prod_sin  (prod_sin)
    );

    qm_window #(.PROD_W(PROD_W), .NMAX(NMAX)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_len  (win_len),
        .prod_vld (prod_vld),
        .prod_cos (prod_cos),
        .prod_sin (prod_sin),
        .avg_vld  (avg_vld),
        .avg_cos  (cos_avg),
        .avg_sin  (sin_avg)
    );

endmodule

// File: tb/tb_quad_mix_avg.sv
module tb_quad_mix_avg;
    localparam int CLK_PERIOD = 10;
    localparam int NMAX = 64;
    localparam real PI = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [15:0] smp = '0;
    logic [31:0]        phase_inc = '0;
    logic [6:0]         win_len = 7'd16;
    logic               avg_vld;
    logic signed [32:0] cos_avg;
    logic signed [32:0] sin_avg;

    quad_mix_avg dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
        .phase_inc(phase_inc), .win_len(win_len),
        .avg_vld(avg_vld), .cos_avg(cos_avg), .sin_avg(sin_avg)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    // behavioural model state
    logic [31:0] m_phase = '0;
    int          m_n = 16;
    longint      qc[$];
    longint      qs[$];
    longint      exp_cos = 0;
    longint      exp_sin = 0;
    bit          exp_vld = 1'b0;

    function automatic int ref_sin(input int k);
        return int'(32767.0 * $sin(2.0 * PI * (real'(k) + 0.5) / 1024.0));
    endfunction

    function automatic bit legal(input int n);
        return n >= 2 && n <= NMAX;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // every-clock comparison against the model (R2 R3 R4 R5 R6 R7 R8)
    always @(negedge clk) begin
        if (cmp_en) begin
            check(avg_vld == exp_vld, "R6 valid", longint'(avg_vld), longint'(exp_vld));
            check(longint'(cos_avg) == exp_cos, "R2 R3 R4 R5 cos", longint'(cos_avg), exp_cos);
            check(longint'(sin_avg) == exp_sin, "R2 R3 R4 R5 sin", longint'(sin_avg), exp_sin);
        end
    end

    task automatic do_smp(input int x);
        int k;
        longint pc, ps, sc, ss;
        @(negedge clk);
        smp = 16'(x);
        smp_vld = 1'b1;
        k = int'(m_phase >> 22);
        pc = longint'(x) * longint'(ref_sin((k + 256) % 1024));
        ps = longint'(x) * longint'(ref_sin(k));
        m_phase = m_phase + phase_inc;
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
        @(posedge clk);
        if (legal(m_n)) begin
            qc.push_back(pc);
            qs.push_back(ps);
            if (qc.size() > m_n) begin
                void'(qc.pop_front());
                void'(qs.pop_front());
            end
            sc = 0; ss = 0;
            foreach (qc[i]) sc += qc[i];
            foreach (qs[i]) ss += qs[i];
            exp_cos = (2 * sc) / m_n;
            exp_sin = (2 * ss) / m_n;
            exp_vld = (qc.size() == m_n);
        end
    endtask

    task automatic set_n(input int n);
        @(negedge clk);
        win_len = 7'(n);
        @(posedge clk);
        if (n != m_n) begin
            m_n = n;
            qc.delete();
            qs.delete();
            exp_cos = 0; exp_sin = 0; exp_vld = 1'b0;
        end
    endtask

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(avg_vld == 1'b0, "R1 vld", longint'(avg_vld), 0);
        check(cos_avg == '0 && sin_avg == '0, "R1 outputs", longint'(cos_avg), 0);
        cmp_en = 1'b1;

        // fundamental, 16 samples per period (R3 R9)
        phase_inc = 32'h1000_0000;
        for (int i = 0; i < 20; i++)
            do_smp(int'(1000.0 * $cos(2.0 * PI * real'(i) / 16.0 + 0.05)));
        check(avg_vld == 1'b1, "R6 full window", longint'(avg_vld), 1);
        check(longint'(cos_avg) > 32438000 && longint'(cos_avg) < 33094000,
              "R9 fundamental", longint'(cos_avg), 32767000);

        // R7: length change restarts
        set_n(8);
        @(negedge clk);
        check(!avg_vld && cos_avg == '0 && sin_avg == '0, "R7 restart", longint'(cos_avg), 0);
        phase_inc = 32'h2000_0000;
        for (int i = 0; i < 12; i++) do_smp(3000 - 500 * i);

        // third harmonic over a 64-sample period (R9, R10 at NMAX)
        set_n(NMAX);
        phase_inc = 32'h0400_0000;
        for (int i = 0; i < 70; i++)
            do_smp(int'(8000.0 * $sin(3.0 * 2.0 * PI * real'(i) / 64.0)));
        check(longint'(cos_avg) < 1048576 && longint'(cos_avg) > -1048576,
              "R9 harmonic cos", longint'(cos_avg), 0);
        check(longint'(sin_avg) < 1048576 && longint'(sin_avg) > -1048576,
              "R9 harmonic sin", longint'(sin_avg), 0);

        // R8: illegal lengths admit nothing
        set_n(1);
        for (int i = 0; i < 4; i++) do_smp(20000);
        check(!avg_vld && cos_avg == '0, "R8 length 1", longint'(cos_avg), 0);
        set_n(NMAX + 1);
        for (int i = 0; i < 4; i++) do_smp(-20000);
        check(!avg_vld && sin_avg == '0, "R8 length 65", longint'(sin_avg), 0);

        // pseudo-random samples, shortest window, odd tuning word (R4 R5 R10)
        set_n(2);
        phase_inc = 32'h0123_4567;
        lfsr = 32'h1ACE_B00C;
        do_smp(-32768);
        do_smp(-32768);
        for (int i = 0; i < 30; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
            do_smp(int'($signed(lfsr[15:0])));
        end
        // longest window with full-scale extremes (R10)
        set_n(NMAX);
        for (int i = 0; i < 80; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
            do_smp((i % 7 == 0) ? -32768 : int'($signed(lfsr[15:0])));
        end
        // R5: outputs hold with no strobe
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(avg_vld == 1'b1, "R5 hold vld", longint'(avg_vld), 1);

        cmp_en = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule